// File: doc/BRIEF.md
# Pulse Handshake Bus Handover Arbiter

This block sits beside the bus unit of a bus owner and lends the local bus to other masters. Each master has its own active-low request/grant line, shared in both directions. A handover takes three pulses on that line, each exactly one clock wide. The master pulses to ask for the bus, the owner pulses back to grant it, and later the master pulses again to give the bus back. The block watches the current bus-cycle phase, a lock indication and a first-interrupt-acknowledge indication. From these it decides when a grant may go out. It then tells the bus unit to float its drivers and to enter the hold state.

Channel 0 takes precedence over channel 1. A request that cannot be served at once is not dropped: it stays pending and is looked at again at the end of each later bus cycle. At least one clock with the owner in control separates one handover from the next.

Top module: `handover_arbiter`

## Requirements
- R1: After reset there are no pending requests, no line is pulled, `bus_float` and `in_hold` are 0, and the owner holds the bus.
- R2: A request is one clock of the line sampled low. The grant is one clock of `rg_pull` high on that channel. It starts on the clock after the request was captured, provided the grant is allowed then. `rg_pull` never stays high for two clocks running.
- R3: `bus_float` rises with the grant pulse. `in_hold` rises on the clock after the grant pulse and stays high, along with `hold_chan` (the channel index), until release.
- R4: A low sample on the holding channel's line ends the hold, and both `bus_float` and `in_hold` fall on the next clock. The clock after that is a dead clock with no grant. The earliest next grant comes one clock later.
- R5: When both channels are eligible on the same clock, channel 0 is granted and channel 1 stays pending.
- R6: Phase codes on `bus_tstate` are 0 idle, 1 T1, 2 T2, 3 T3, 4 T4 and 5 wait. A request sampled in phase idle, T1, T2 or T4 is eligible at the next T4 or idle sample. A request sampled in T3 or wait skips the T4 of the current cycle and becomes eligible after it.
- R7: No grant is given on a clock where `bus_lock` is high. The request stays pending and is granted once lock is low.
- R8: No grant is given on a clock where `inta_first` is high. The request stays pending.
- R9: A request on the other channel during a handover is captured and granted after the release and the dead clock.
- R10: A pulse on the non-holding channel does not end the current hold.
- R11: A grant is only issued when the sampled phase is T4 or idle, never during T1, T2, T3 or a wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rg_line_n | input | NUM_CH | Sampled level of each request/grant line, low active |
| rg_pull | output | NUM_CH | High drives the line low for a grant pulse |
| bus_tstate | input | 3 | Current bus-cycle phase code (see R6) |
| bus_lock | input | 1 | Locked instruction in progress |
| inta_first | input | 1 | First pulse of an interrupt-acknowledge pair in progress |
| bus_float | output | 1 | Bus unit must float its local bus drivers |
| in_hold | output | 1 | Hold state entered, bus lent out |
| hold_chan | output | CH_W | Index of the channel that holds or is being granted the bus |

## Verification
The block is driven four ways:
- Requests on an idle bus show the basic three-pulse timing and the dead clock.
- Simultaneous requests, and requests made during another handover, separate the channel precedence from the deferral of a captured request.
- Requests placed in T2, T3 and a wait state of running cycles show whether the late-request rule shifts the grant by exactly one bus cycle.
- Lock and first-acknowledge windows confirm that a blocked request survives and is granted once the block clears.

// File: rtl/hoa_pkg.sv
package hoa_pkg;
  // phase codes carried on bus_tstate
  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_T1   = 3'd1;
  localparam logic [2:0] PH_T2   = 3'd2;
  localparam logic [2:0] PH_T3   = 3'd3;
  localparam logic [2:0] PH_T4   = 3'd4;
  localparam logic [2:0] PH_TW   = 3'd5;

  typedef enum logic [1:0] {
    ST_OWN    = 2'd0,  // owner drives the bus
    ST_GIVE   = 2'd1,  // grant pulse on the line
    ST_LENT   = 2'd2,  // hold: another master drives the bus
    ST_SETTLE = 2'd3   // dead clock after release
  } own_e;

  // a request seen in this phase is too late for the current T4
  function automatic logic is_late_phase(input logic [2:0] ph);
    return (ph == PH_T3) || (ph == PH_TW);
  endfunction

  // phases in which the bus may change hands
  function automatic logic is_hand_phase(input logic [2:0] ph);
    return (ph == PH_T4) || (ph == PH_IDLE);
  endfunction
endpackage

// File: rtl/hoa_capture.sv
module hoa_capture
  import hoa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_low,
  input  logic       watch,
  input  logic [2:0] phase,
  input  logic       clear,
  output logic       pend,
  output logic       ready
);
  logic late;
  logic arrive;

  assign arrive = watch && line_low && !pend;
  assign ready  = pend && !late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      late <= 1'b0;
    end else if (clear) begin
      pend <= 1'b0;
      late <= 1'b0;
    end else if (arrive) begin
      pend <= 1'b1;
      late <= is_late_phase(phase);
    end else if (phase == PH_T4) begin
      late <= 1'b0;
    end
  end

  // R6: only a captured request can be consumed by a grant
  p_clear_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> pend);
endmodule

// File: rtl/hoa_select.sv
module hoa_select #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic [NUM_CH-1:0] ready,
  input  logic              window,
  output logic              fire,
  output logic [CH_W-1:0]   idx
);
  // lowest index wins: scan from the top so the lowest ready one is kept
  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ready[i]) idx = CH_W'(i);
    end
  end

  assign fire = window && (|ready);
endmodule

// File: rtl/handover_arbiter.sv
module handover_arbiter
  import hoa_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rg_line_n,
  output logic [NUM_CH-1:0] rg_pull,
  input  logic [2:0]        bus_tstate,
  input  logic              bus_lock,
  input  logic              inta_first,
  output logic              bus_float,
  output logic              in_hold,
  output logic [CH_W-1:0]   hold_chan
);
  own_e              st;
  logic [CH_W-1:0]   act;
  logic [NUM_CH-1:0] line_low;
  logic [NUM_CH-1:0] watch;
  logic [NUM_CH-1:0] taken;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] ready;
  logic              window;
  logic              grant_fire;
  logic [CH_W-1:0]   grant_idx;
  logic              release_seen;

  assign line_low = ~rg_line_n;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // the lent channel's line carries our grant and its release, not a request
      assign watch[c] = (st == ST_OWN) || (st == ST_SETTLE) || (act != CH_W'(c));
      assign taken[c] = grant_fire && (grant_idx == CH_W'(c));
      hoa_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_low (line_low[c]),
        .watch    (watch[c]),
        .phase    (bus_tstate),
        .clear    (taken[c]),
        .pend     (pend[c]),
        .ready    (ready[c])
      );
    end
  endgenerate

  assign window = (st == ST_OWN) && is_hand_phase(bus_tstate) && !bus_lock && !inta_first;

  hoa_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .ready  (ready),
    .window (window),
    .fire   (grant_fire),
    .idx    (grant_idx)
  );

  assign release_seen = (st == ST_LENT) && line_low[act];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OWN;
      act <= '0;
    end else begin
      unique case (st)
        ST_OWN: if (grant_fire) begin
          st  <= ST_GIVE;
          act <= grant_idx;
        end
        ST_GIVE:   st <= ST_LENT;
        ST_LENT:   if (release_seen) st <= ST_SETTLE;
        ST_SETTLE: st <= ST_OWN;
        default:   st <= ST_OWN;
      endcase
    end
  end

  always_comb begin
    rg_pull = '0;
    if (st == ST_GIVE) rg_pull[act] = 1'b1;
  end

  assign bus_float = (st == ST_GIVE) || (st == ST_LENT);
  assign in_hold   = (st == ST_LENT);
  assign hold_chan = act;

  // R2: a grant pulse lasts exactly one clock
  p_grant_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rg_pull) |=> (rg_pull == '0));
  // R3: hold follows the grant pulse
  p_hold_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rg_pull) |=> in_hold);
  // R4: release returns the bus on the next clock
  p_release_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && line_low[hold_chan]) |=> !bus_float);
  // R4: dead clock after every handover
  p_dead_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float) |=> (rg_pull == '0));
  // R5: never more than one channel granted
  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rg_pull));
  // R11: grants only on a T4 or idle sample
  p_grant_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> is_hand_phase(bus_tstate));
  // R7: lock blocks grants
  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> !bus_lock);
  // R8: first acknowledge blocks grants
  p_inta_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> !inta_first);
endmodule

// File: tb/tb_handover_arbiter.sv
module tb_handover_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_low = 2'b00;
  logic [1:0] line_n;
  logic [1:0] pull;
  logic [2:0] tstate = 3'd0;
  logic       lock = 1'b0;
  logic       inta = 1'b0;
  logic       flt;
  logic       hold;
  logic       hch;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // wired-low line: master or owner may pull it
  assign line_n = ~(ext_low | pull);

  handover_arbiter dut (
    .clk(clk), .rst_n(rst_n), .rg_line_n(line_n), .rg_pull(pull),
    .bus_tstate(tstate), .bus_lock(lock), .inta_first(inta),
    .bus_float(flt), .in_hold(hold), .hold_chan(hch)
  );

  // behavioural reference: 0 own, 1 granting, 2 lent, 3 dead clock
  int m_st = 0;
  int m_act = 0;
  int m_pend[2];
  int m_wait[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_act = 0;
      for (int c = 0; c < 2; c++) begin m_pend[c] = 0; m_wait[c] = 0; end
    end else begin
      int pick;
      bit ok;
      ok = (m_st == 0) && (tstate == 3'd4 || tstate == 3'd0) && !lock && !inta;
      pick = -1;
      for (int c = 0; c < 2; c++)
        if (ok && pick < 0 && m_pend[c] != 0 && m_wait[c] == 0) pick = c;
      for (int c = 0; c < 2; c++) begin
        bit low, seen;
        low  = ext_low[c] || (m_st == 1 && m_act == c);
        seen = (m_st == 0) || (m_st == 3) || (m_act != c);
        if (pick == c) begin
          m_pend[c] = 0; m_wait[c] = 0;
        end else if (seen && low && m_pend[c] == 0) begin
          m_pend[c] = 1;
          m_wait[c] = (tstate == 3'd3 || tstate == 3'd5) ? 1 : 0;
        end else if (tstate == 3'd4 && m_wait[c] > 0) begin
          m_wait[c] = m_wait[c] - 1;
        end
      end
      case (m_st)
        0: if (pick >= 0) begin m_st = 1; m_act = pick; end
        1: m_st = 2;
        2: if (ext_low[m_act]) m_st = 3;
        default: m_st = 0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the reference (R2 R3 R4 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ep;
      ep = (m_st == 1) ? (1 << m_act) : 0;
      check("model pull R2", int'(pull), ep);
      check("model float R3", int'(flt), (m_st == 1 || m_st == 2) ? 1 : 0);
      check("model hold R3", int'(hold), (m_st == 2) ? 1 : 0);
      if (m_st == 2) check("model chan R3", int'(hch), m_act);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input int c);
    ext_low[c] = 1'b1;
    step();
    ext_low[c] = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 pull", int'(pull), 0);
    check("R1 float", int'(flt), 0);
    check("R1 hold", int'(hold), 0);

    // idle request on channel 1
    pulse(1);
    step();
    check("R2 grant ch1", int'(pull), 2);
    check("R3 float with grant", int'(flt), 1);
    step();
    check("R2 pulse one clock", int'(pull), 0);
    check("R3 hold", int'(hold), 1);
    check("R3 hold chan", int'(hch), 1);
    step(); step();

    // channel 0 asks during the handover
    pulse(0);
    check("R10 other pulse keeps hold", int'(flt), 1);
    pulse(1);
    check("R4 release", int'(flt), 0);
    step();
    check("R4 dead clock", int'(pull), 0);
    step();
    check("R9 deferred grant ch0", int'(pull), 1);
    step();
    pulse(0);
    step(); step();

    // simultaneous requests
    ext_low = 2'b11;
    step();
    ext_low = 2'b00;
    step();
    check("R5 ch0 wins", int'(pull), 1);
    step();
    pulse(0);
    step(); step();
    check("R5 ch1 after", int'(pull), 2);
    step();
    pulse(1);
    step(); step();

    // early request in T2
    tstate = 3'd1; step();
    tstate = 3'd2; ext_low[0] = 1'b1; step();
    ext_low[0] = 1'b0; tstate = 3'd3; step();
    check("R11 no grant mid cycle", int'(pull), 0);
    tstate = 3'd4; step();
    check("R6 early grant at T4", int'(pull), 1);
    tstate = 3'd0; step();
    pulse(0);
    step(); step();

    // late request in T3
    tstate = 3'd1; step();
    tstate = 3'd2; step();
    tstate = 3'd3; ext_low[0] = 1'b1; step();
    ext_low[0] = 1'b0; tstate = 3'd4; step();
    check("R6 late skips T4", int'(pull), 0);
    tstate = 3'd1; step();
    tstate = 3'd2; step();
    tstate = 3'd3; step();
    check("R11 none in T3", int'(pull), 0);
    tstate = 3'd4; step();
    check("R6 late grant next T4", int'(pull), 1);
    tstate = 3'd0; step();
    pulse(0);
    step(); step();

    // late request in a wait state
    tstate = 3'd1; step();
    tstate = 3'd2; step();
    tstate = 3'd3; step();
    tstate = 3'd5; ext_low[1] = 1'b1; step();
    ext_low[1] = 1'b0; tstate = 3'd4; step();
    check("R6 wait request skips T4", int'(pull), 0);
    tstate = 3'd0; step();
    check("R6 wait request granted idle", int'(pull), 2);
    step();
    pulse(1);
    step(); step();

    // lock
    lock = 1'b1;
    pulse(1);
    step(); step(); step();
    check("R7 lock blocks", int'(pull), 0);
    lock = 1'b0; step();
    check("R7 granted after lock", int'(pull), 2);
    step();
    pulse(1);
    step(); step();

    // first interrupt acknowledge
    inta = 1'b1;
    pulse(0);
    step(); step();
    check("R8 inta blocks", int'(pull), 0);
    inta = 1'b0; step();
    check("R8 granted after inta", int'(pull), 1);
    step();
    pulse(0);
    step(); step();
    check("R4 back to owner", int'(flt), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule